// File: doc/BRIEF.md
# Accumulator and Link Datapath

This block holds a 16-bit working register and a single link bit beside it. A controller selects one operation per cycle by raising exactly one strobe in a one-hot vector. The operations are: AND with an operand word, add the operand word, copy the operand word, take the low byte from an 8-bit input port, invert, rotate right or left through the link, clear, increment, clear the link, and invert the link. The add writes its carry-out into the link. Both rotates pass through the link, so the register and the link together act as a 17-bit ring.

The operand word and the input byte arrive on plain ports. Three combinational status outputs support skip decisions in a controller: the sign bit, a flag that shows when the whole accumulator is zero, and a flag that shows when the link is zero. If two or more strobes are raised in the same cycle, the state does not change and an error flag is raised for that cycle.

Top module: `acc_link_dp`

## Requirements
- R1: A synchronous reset clears both the accumulator and the link.
- R2: The AND strobe (op bit 0) sets acc to acc & operand and leaves the link unchanged.
- R3: The add strobe (op bit 1) sets acc to the low 16 bits of acc + operand and sets the link to the carry-out.
- R4: The load strobe (op bit 2) copies the operand into acc. The byte strobe (op bit 3) writes the input byte to acc bits 7..0 and clears bits 15..8. Neither strobe changes the link.
- R5: The invert strobe (op bit 4) complements every acc bit. The clear strobe (op bit 7) sets acc to zero. Neither strobe changes the link.
- R6: The rotate-right strobe (op bit 5) shifts acc right by one. The old link enters bit 15 and the old bit 0 goes to the link.
- R7: The rotate-left strobe (op bit 6) shifts acc left by one. The old link enters bit 0 and the old bit 15 goes to the link.
- R8: The increment strobe (op bit 8) adds 1 to acc modulo 2^16 and leaves the link unchanged.
- R9: Op bit 9 clears the link and op bit 10 complements the link. Both leave acc unchanged.
- R10: The status outputs are combinational: sign equals acc bit 15, acc_zero is high exactly when acc is 0, and link_zero is high exactly when the link is 0.
- R11: When no strobe is raised, acc and the link hold their values and op_err is low.
- R12: When more than one strobe is raised, op_err is high in that cycle and acc and the link do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op | input | 11 | One-hot operation strobes |
| operand | input | 16 | Operand word |
| in_byte | input | 8 | Input byte |
| acc | output | 16 | Accumulator |
| link | output | 1 | Link bit |
| sign | output | 1 | Accumulator bit 15 |
| acc_zero | output | 1 | High when the accumulator is zero |
| link_zero | output | 1 | High when the link is zero |
| op_err | output | 1 | More than one strobe raised |

## Verification
Each operation's result appears in acc and link one clock edge after its strobe is applied. The status flags follow the new register value in the same delta, and op_err is combinational within the cycle of the strobe. The bench drives each stimulus on the falling edge, reads op_err before the next rising edge, and compares acc, link and the flags after that edge, half a period later. The sweep covers every operation, pairs of strobes and several operand patterns, including the carry and wrap corners.

// File: rtl/acc_link_dp.sv
module acc_link_dp #(
  parameter int W  = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [10:0]   op,
  input  logic [W-1:0]  operand,
  input  logic [BW-1:0] in_byte,
  output logic [W-1:0]  acc,
  output logic          link,
  output logic          sign,
  output logic          acc_zero,
  output logic          link_zero,
  output logic          op_err
);
  logic [W-1:0] acc_nx;
  logic         link_nx;
  logic [W:0]   sum;

  assign sum       = {1'b0, acc} + {1'b0, operand};
  assign op_err    = $countones(op) > 1;
  assign sign      = acc[W-1];
  assign acc_zero  = (acc == '0);
  assign link_zero = ~link;

  always_comb begin
    acc_nx  = acc;
    link_nx = link;
    if (!op_err) begin
      unique case (1'b1)
        op[0]:  acc_nx = acc & operand;
        op[1]:  {link_nx, acc_nx} = sum;
        op[2]:  acc_nx = operand;
        op[3]:  acc_nx = {{(W-BW){1'b0}}, in_byte};
        op[4]:  acc_nx = ~acc;
        op[5]:  {acc_nx, link_nx} = {link, acc};
        op[6]:  {link_nx, acc_nx} = {acc, link};
        op[7]:  acc_nx = '0;
        op[8]:  acc_nx = acc + 1'b1;
        op[9]:  link_nx = 1'b0;
        op[10]: link_nx = ~link;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      link <= 1'b0;
    end else begin
      acc  <= acc_nx;
      link <= link_nx;
    end
  end
endmodule

// File: rtl/acc_link_dp_chk.sv
module acc_link_dp_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [10:0]  op,
  input logic [W-1:0] operand,
  input logic [W-1:0] acc,
  input logic         link,
  input logic         op_err
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (acc == '0 && !link)); // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (op == '0) |=> ($stable(acc) && $stable(link))); // R11
  AST_MULTI_FROZEN: assert property (@(posedge clk) disable iff (rst)
    ($countones(op) > 1) |=> ($stable(acc) && $stable(link))); // R12
  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (rst)
    (op == 11'h004) |=> (acc == $past(operand) && $stable(link))); // R4
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (op == 11'h080) |=> (acc == '0)); // R5
  AST_LINK_OPS_KEEP_ACC: assert property (@(posedge clk) disable iff (rst)
    (op == 11'h200 || op == 11'h400) |=> $stable(acc)); // R9
  AST_INC_KEEPS_LINK: assert property (@(posedge clk) disable iff (rst)
    (op == 11'h100) |=> $stable(link)); // R8
endmodule

bind acc_link_dp acc_link_dp_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .op(op), .operand(operand),
  .acc(acc), .link(link), .op_err(op_err));

// File: tb/test_acc_link_dp.sv
module test_acc_link_dp;
  logic clk = 0;
  logic rst;
  logic [10:0] op;
  logic [15:0] operand;
  logic [7:0]  in_byte;
  logic [15:0] acc;
  logic link, sign, acc_zero, link_zero, op_err;
  int n_vec = 0, n_bad = 0;
  logic [15:0] m_acc;
  logic m_link;

  always #5 clk = ~clk;

  acc_link_dp i_acc_link_dp (.clk, .rst, .op, .operand, .in_byte,
    .acc, .link, .sign, .acc_zero, .link_zero, .op_err);

  initial begin
    #1500000;
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  task automatic check(string req, logic [15:0] ea, logic el);
    n_vec++;
    if (acc !== ea || link !== el || sign !== ea[15] ||
        acc_zero !== (ea == 0) || link_zero !== !el) begin
      n_bad++;
      $display("FAIL %s: actual acc=%h link=%b s=%b z=%b lz=%b expected acc=%h link=%b",
               req, acc, link, sign, acc_zero, link_zero, ea, el);
    end
  endtask

  function automatic void model(logic [10:0] o, logic [15:0] d, logic [7:0] b);
    logic [16:0] s;
    if ($countones(o) != 1) return;
    case (1'b1)
      o[0]: m_acc = m_acc & d;
      o[1]: begin s = {1'b0, m_acc} + {1'b0, d}; m_acc = s[15:0]; m_link = s[16]; end
      o[2]: m_acc = d;
      o[3]: m_acc = {8'h00, b};
      o[4]: m_acc = ~m_acc;
      o[5]: begin s = {m_link, m_acc}; m_link = s[0]; m_acc = s[16:1]; end
      o[6]: begin s = {m_acc, m_link}; m_link = s[16]; m_acc = s[15:0]; end
      o[7]: m_acc = 16'h0;
      o[8]: m_acc = m_acc + 16'h1;
      o[9]: m_link = 1'b0;
      o[10]: m_link = ~m_link;
      default: ;
    endcase
  endfunction

  function automatic string tag(logic [10:0] o);
    if ($countones(o) > 1) return "R12";
    if (o == 0)  return "R11";
    if (o[0]) return "R2";
    if (o[1]) return "R3";
    if (o[2] || o[3]) return "R4";
    if (o[4] || o[7]) return "R5";
    if (o[5]) return "R6";
    if (o[6]) return "R7";
    if (o[8]) return "R8";
    return "R9";
  endfunction

  task automatic apply(logic [10:0] o, logic [15:0] d, logic [7:0] b);
    @(negedge clk);
    op = o; operand = d; in_byte = b;
    #2;
    n_vec++;
    if (op_err !== ($countones(o) > 1)) begin
      n_bad++;
      $display("FAIL R12: op_err actual=%b expected=%b op=%h", op_err, $countones(o) > 1, o);
    end
    model(o, d, b);
    @(posedge clk); #1;
    check(tag(o), m_acc, m_link);
    check("R10", m_acc, m_link);
  endtask

  initial begin
    logic [15:0] pats [8];
    pats = '{16'h0000, 16'hFFFF, 16'h8000, 16'h0001, 16'hA937, 16'h5A5A, 16'h7FFF, 16'h1234};
    rst = 1; op = 0; operand = 16'hFFFF; in_byte = 8'hFF;
    @(posedge clk); @(posedge clk); #1;
    m_acc = 0; m_link = 0;
    check("R1", 16'h0, 1'b0);
    rst = 0;
    for (int s = 0; s < 8; s++)
      for (int k = 0; k < 11; k++) begin
        apply(11'h004, pats[s], 8'h00);
        if (s[0]) apply(11'h400, 16'h0, 8'h0);
        apply(11'(1) << k, pats[(s + k) % 8], pats[(s + 3) % 8][7:0] ^ 8'hC3);
      end
    apply(11'h004, 16'hFFFF, 0); apply(11'h100, 0, 0);
    apply(11'h004, 16'h8000, 0); apply(11'h002, 16'h8000, 0);
    apply(11'h004, 16'hFFFF, 0); apply(11'h002, 16'h0001, 0);
    for (int i = 0; i < 20; i++) apply(11'h020, 0, 0);
    for (int i = 0; i < 20; i++) apply(11'h040, 0, 0);
    apply(11'h000, 16'h1111, 8'h22);
    for (int a = 0; a < 11; a++)
      for (int c = a + 1; c < 11; c++)
        apply((11'(1) << a) | (11'(1) << c), 16'hBEEF, 8'h5C);
    apply(11'h7FF, 16'h0F0F, 8'h77);
    rst = 1; @(posedge clk); #1; rst = 0;
    m_acc = 0; m_link = 0;
    check("R1", 16'h0, 1'b0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule